// File: doc/BRIEF.md
# Atomic Word Read-Modify-Write Unit

This unit sits between a core's load/store path and a single-port data memory and carries out one atomic operation on one 32-bit word per request. A request brings an operation code, a base address, a signed 10-bit offset, and a register pair. The first register of the pair holds the value to store. The second holds either the compare value or a bit mask. The unit reads the addressed word and works out the write value. It then writes that value back and returns the word that was in memory before the write. While this runs it holds a lock line high so that no other requester can reach the memory between the read and the write.

Two operations are provided. Compare-and-swap always writes. It stores the new value when the compare value matches the old word, and writes the old word back unchanged when it does not. Masked swap takes each bit from the data register where the mask bit is one, and from the old word where the mask bit is zero. Each operation has three address forms:

- The offset form adds the sign-extended offset to the base and leaves the base unchanged.
- The post-increment form uses the base as the address and returns base plus offset as the new base.
- The pre-increment form uses base plus offset both as the address and as the new base.

An operation code outside the six defined values makes no memory access. It raises a one-cycle illegal flag instead.

Top module: `atomic_rmw`

## Requirements
- R1: While reset is asserted and after it is released, busy, rsp_valid, base_upd_valid, illegal_op, mem_req and mem_lock are all low.
- R2: Compare-and-swap with req_aux equal to the old word writes req_data to the addressed word.
- R3: Compare-and-swap with req_aux different from the old word still performs a write, and that write stores the old word unchanged.
- R4: Masked swap writes (req_data AND req_aux) OR (old AND NOT req_aux), bit by bit.
- R5: rsp_data carries the word that was in memory before the write, in the cycle rsp_valid is high.
- R6: The offset form (bits [5:4] of req_op = 2'b10) accesses req_base plus the sign-extended offset, and base_upd_valid stays low.
- R7: The post-increment form (bits [5:4] = 2'b00) accesses req_base, and returns req_base plus offset on base_upd with base_upd_valid high in the response cycle.
- R8: The pre-increment form (bits [5:4] = 2'b01) accesses req_base plus offset, and returns that same value on base_upd with base_upd_valid high in the response cycle.
- R9: The legal codes of req_op are 0x23, 0x03 and 0x13 for compare-and-swap and 0x22, 0x02 and 0x12 for masked swap, in offset, post-increment and pre-increment form respectively.
- R10: An accepted request produces this sequence:
  - a read in the 1st cycle after acceptance;
  - no memory request in the 2nd cycle;
  - the write in the 3rd cycle;
  - rsp_valid in the 4th cycle.
  mem_lock is high from the read through the write, and busy is high for all four cycles. A request presented while busy is ignored.
- R11: Any other req_op value gives no memory request and no busy. illegal_op is high for exactly the one cycle after the request.
- R12: The offset is a two's-complement 10-bit value, so 10'h200 subtracts 512 and 10'h3FC subtracts 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_op | input | 6 | Operation code |
| req_base | input | ADDR_W | Base address |
| req_off | input | OFF_W | Signed offset |
| req_data | input | DATA_W | Store value (first register of the pair) |
| req_aux | input | DATA_W | Compare value or mask (second register of the pair) |
| busy | output | 1 | Operation in progress; new requests are ignored |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | DATA_W | Old memory word |
| base_upd_valid | output | 1 | New base is valid (increment forms only) |
| base_upd | output | ADDR_W | New base address |
| illegal_op | output | 1 | Unknown operation code seen |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_lock | output | 1 | Memory held exclusively for this unit |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after a read request |

## Verification
The hardest case to reach from the ports is a second request that arrives in the middle of an operation. The memory is locked and the write is still pending at that point. The stimulus therefore raises req_valid again in the cycle between the read and the write. The bench then checks on every cycle that the memory request pattern, the lock and the busy window stay exactly those of the first operation. The two compare-and-swap outcomes need the compare value to track the word that earlier operations left behind. The bench takes that value from its own running image of memory. This means a matching compare still lands after several writes to the same address. The sign of the offset is driven at its most negative value so that a wrong extension shows up in the address.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;

   localparam int OPC_W = 6;

   typedef enum logic {
      KIND_MSK = 1'b0,
      KIND_CAS = 1'b1
   } kind_e;

   typedef enum logic [1:0] {
      AM_POST  = 2'b00,
      AM_PRE   = 2'b01,
      AM_SHORT = 2'b10,
      AM_NONE  = 2'b11
   } amode_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD   = 3'd1,
      ST_WAIT = 3'd2,
      ST_WR   = 3'd3,
      ST_RSP  = 3'd4
   } state_e;

endpackage

// File: rtl/atomic_rmw_decode.sv
module atomic_rmw_decode
   import atomic_rmw_pkg::*;
(
   input  logic [OPC_W-1:0] op,
   output logic             legal,
   output kind_e            kind,
   output amode_e           mode
);
   always_comb begin
      kind  = op[0] ? KIND_CAS : KIND_MSK;
      mode  = amode_e'(op[5:4]);
      legal = (op[3:1] == 3'b001) && (op[5:4] != 2'b11);
   end
endmodule

// File: rtl/atomic_rmw_agen.sv
module atomic_rmw_agen
   import atomic_rmw_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 10
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFF_W-1:0]  off,
   input  amode_e            mode,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] new_base,
   output logic              upd
);
   localparam int EXT_W = ADDR_W - OFF_W;

   logic [ADDR_W-1:0] off_ext;
   logic [ADDR_W-1:0] sum;

   always_comb begin
      off_ext  = {{EXT_W{off[OFF_W-1]}}, off};
      sum      = base + off_ext;
      addr     = (mode == AM_POST) ? base : sum;
      new_base = sum;
      upd      = (mode == AM_POST) || (mode == AM_PRE);
   end
endmodule

// File: rtl/atomic_rmw_merge.sv
module atomic_rmw_merge
   import atomic_rmw_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  kind_e             kind,
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] aux,
   output logic [DATA_W-1:0] wdata
);
   logic [DATA_W-1:0] msk_word;
   logic [DATA_W-1:0] cas_word;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign msk_word[b] = aux[b] ? data[b] : old_word[b];
   end

   assign cas_word = (aux == old_word) ? data : old_word;
   assign wdata    = (kind == KIND_CAS) ? cas_word : msk_word;
endmodule

// File: rtl/atomic_rmw.sv
module atomic_rmw
   import atomic_rmw_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int OFF_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [5:0]        req_op,
   input  logic [ADDR_W-1:0] req_base,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [DATA_W-1:0] req_data,
   input  logic [DATA_W-1:0] req_aux,
   output logic              busy,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              base_upd_valid,
   output logic [ADDR_W-1:0] base_upd,
   output logic              illegal_op,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_lock,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   if (OFF_W < 2 || OFF_W >= ADDR_W) begin : g_bad_off
      $error("atomic_rmw: OFF_W must lie between 2 and ADDR_W-1");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("atomic_rmw: DATA_W must be at least 8");
   end

   state_e            state;
   kind_e             kind_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] base_q;
   logic              upd_q;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] aux_q;
   logic [DATA_W-1:0] old_q;
   logic [DATA_W-1:0] wdata_q;
   logic              illegal_q;

   logic              dec_legal;
   kind_e             dec_kind;
   amode_e            dec_mode;
   logic [ADDR_W-1:0] ag_addr;
   logic [ADDR_W-1:0] ag_base;
   logic              ag_upd;
   logic [DATA_W-1:0] mg_wdata;

   atomic_rmw_decode u_dec (
      .op    (req_op),
      .legal (dec_legal),
      .kind  (dec_kind),
      .mode  (dec_mode)
   );

   atomic_rmw_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
      .base     (req_base),
      .off      (req_off),
      .mode     (dec_mode),
      .addr     (ag_addr),
      .new_base (ag_base),
      .upd      (ag_upd)
   );

   atomic_rmw_merge #(.DATA_W(DATA_W)) u_merge (
      .kind     (kind_q),
      .old_word (mem_rdata),
      .data     (data_q),
      .aux      (aux_q),
      .wdata    (mg_wdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind_q    <= KIND_MSK;
         addr_q    <= '0;
         base_q    <= '0;
         upd_q     <= 1'b0;
         data_q    <= '0;
         aux_q     <= '0;
         old_q     <= '0;
         wdata_q   <= '0;
         illegal_q <= 1'b0;
      end else begin
         illegal_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  if (dec_legal) begin
                     kind_q <= dec_kind;
                     addr_q <= ag_addr;
                     base_q <= ag_base;
                     upd_q  <= ag_upd;
                     data_q <= req_data;
                     aux_q  <= req_aux;
                     state  <= ST_RD;
                  end else begin
                     illegal_q <= 1'b1;
                  end
               end
            end
            ST_RD:   state <= ST_WAIT;
            ST_WAIT: begin
               old_q   <= mem_rdata;
               wdata_q <= mg_wdata;
               state   <= ST_WR;
            end
            ST_WR:   state <= ST_RSP;
            ST_RSP:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy           = (state != ST_IDLE);
   assign mem_req        = (state == ST_RD) || (state == ST_WR);
   assign mem_we         = (state == ST_WR);
   assign mem_lock       = (state == ST_RD) || (state == ST_WAIT) || (state == ST_WR);
   assign mem_addr       = addr_q;
   assign mem_wdata      = wdata_q;
   assign rsp_valid      = (state == ST_RSP);
   assign rsp_data       = old_q;
   assign base_upd_valid = (state == ST_RSP) && upd_q;
   assign base_upd       = base_q;
   assign illegal_op     = illegal_q;

   assert_wr_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_lock && $past(mem_lock)));

   assert_rd_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> (!mem_req && mem_lock));

   assert_rsp_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (busy && !mem_lock));

   assert_cas_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && kind_q == KIND_CAS && aux_q != old_q) |-> (mem_wdata == old_q));

   assert_msk_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && kind_q == KIND_MSK) |->
         (((mem_wdata ^ old_q) & ~aux_q) == '0 && ((mem_wdata ^ data_q) & aux_q) == '0));

   assert_base_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      base_upd_valid |-> rsp_valid);

   assert_illegal_noacc_R11: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_op |-> (!mem_req && !busy));

endmodule

// File: tb/tb_atomic_rmw.sv
`timescale 1ns/1ps
module tb_atomic_rmw;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [5:0]  req_op = '0;
   logic [31:0] req_base = '0;
   logic [9:0]  req_off = '0;
   logic [31:0] req_data = '0;
   logic [31:0] req_aux = '0;
   logic        busy, rsp_valid, base_upd_valid, illegal_op;
   logic        mem_req, mem_we, mem_lock;
   logic [31:0] rsp_data, base_upd, mem_addr, mem_wdata;
   logic [31:0] mem_rdata;

   always #2.5 clk = ~clk;

   atomic_rmw dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_base(req_base), .req_off(req_off), .req_data(req_data), .req_aux(req_aux),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .base_upd_valid(base_upd_valid), .base_upd(base_upd), .illegal_op(illegal_op),
      .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // memory: 16 words, read data one cycle after request
   logic [31:0] mem [16];
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) mem[i] <= 32'h1000_0000 + i * 32'h0101_0101;
         mem_rdata <= '0;
      end else if (mem_req) begin
         if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[5:2]];
      end
   end

   logic [31:0] ref_mem [16];
   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;
   bit chk_on = 0;

   function automatic bit op_ok(input logic [5:0] op);
      return op == 6'h23 || op == 6'h03 || op == 6'h13 ||
             op == 6'h22 || op == 6'h02 || op == 6'h12;
   endfunction

   // cycle reference model
   int cnt = 0;
   bit ill_exp = 0;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= 0;
         ill_exp <= 0;
      end else begin
         ill_exp <= 0;
         if (cnt != 0) cnt <= cnt - 1;
         else if (req_valid) begin
            if (op_ok(req_op)) cnt <= 4;
            else ill_exp <= 1;
         end
      end
   end

   logic [31:0] e_addr, e_new, e_old, e_base;
   bit e_upd;
   int e_idx;
   string t_addr, t_wr, t_base;

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (chk_on) begin
         chk("R10", "busy", {31'b0, busy}, {31'b0, cnt != 0});
         chk("R10", "rsp_valid", {31'b0, rsp_valid}, {31'b0, cnt == 1});
         chk("R10", "mem_req", {31'b0, mem_req}, {31'b0, cnt == 4 || cnt == 2});
         chk("R10", "mem_lock", {31'b0, mem_lock}, {31'b0, cnt >= 2 && cnt <= 4});
         chk("R11", "illegal_op", {31'b0, illegal_op}, {31'b0, ill_exp});
         if (cnt == 4) begin
            chk("R10", "read dir", {31'b0, mem_we}, 32'd0);
            chk(t_addr, "read addr", mem_addr, e_addr);
         end
         if (cnt == 2) begin
            chk("R10", "write dir", {31'b0, mem_we}, 32'd1);
            chk(t_addr, "write addr", mem_addr, e_addr);
            chk(t_wr, "wdata", mem_wdata, e_new);
         end
         if (cnt == 1) begin
            chk("R5", "rsp_data", rsp_data, e_old);
            chk(t_base, "base_upd_valid", {31'b0, base_upd_valid}, {31'b0, e_upd});
            if (e_upd) chk(t_base, "base_upd", base_upd, e_base);
            chk(t_wr, "mem word", mem[e_idx], e_new);
         end
      end
   end

   task automatic run_op(input logic [5:0] op, input logic [31:0] base, input logic [9:0] off,
                         input logic [31:0] d, input logic [31:0] a, input bit aux_is_old,
                         input bit intrude, input string ta, input string tw, input string tb);
      logic [31:0] sum, aux;
      sum = base + {{22{off[9]}}, off};
      e_addr = (op[5:4] == 2'b00) ? base : sum;
      e_base = sum;
      e_upd  = (op[5:4] != 2'b10);
      e_idx  = int'(e_addr[5:2]);
      e_old  = ref_mem[e_idx];
      aux    = aux_is_old ? e_old : a;
      if (op[0]) e_new = (aux == e_old) ? d : e_old;
      else       e_new = (d & aux) | (e_old & ~aux);
      t_addr = ta; t_wr = tw; t_base = tb;
      @(negedge clk);
      req_valid = 1; req_op = op; req_base = base; req_off = off; req_data = d; req_aux = aux;
      @(negedge clk);
      req_valid = 0;
      if (intrude) begin
         @(negedge clk);
         req_valid = 1; req_op = 6'h22; req_base = base ^ 32'h20; req_data = 32'hDEAD_BEEF; req_aux = '1;
         @(negedge clk);
         req_valid = 0;
      end
      while (cnt != 0) @(negedge clk);
      ref_mem[e_idx] = e_new;
      @(negedge clk);
   endtask

   task automatic run_bad(input logic [5:0] op);
      @(negedge clk);
      req_valid = 1; req_op = op; req_base = 32'h40;
      @(negedge clk);
      req_valid = 0;
      @(negedge clk);
      // R11: the word at the requested address is untouched
      chk("R11", "mem untouched", mem[0], ref_mem[0]);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 16; i++) ref_mem[i] = 32'h1000_0000 + i * 32'h0101_0101;
      repeat (3) @(negedge clk);
      // R1: reset state while reset is held
      chk("R1", "busy in reset", {31'b0, busy}, 32'd0);
      chk("R1", "mem_req in reset", {31'b0, mem_req}, 32'd0);
      chk("R1", "rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
      rst_n = 1;
      @(negedge clk);
      chk("R1", "illegal after reset", {31'b0, illegal_op}, 32'd0);
      chk("R1", "lock after reset", {31'b0, mem_lock}, 32'd0);
      chk("R1", "base valid after reset", {31'b0, base_upd_valid}, 32'd0);
      chk_on = 1;

      run_op(6'h23, 32'h40, 10'd8, 32'hCAFE_F00D, '0, 1, 0, "R6", "R2 R9", "R6");
      run_op(6'h23, 32'h40, 10'd8, 32'h1111_2222, '0, 0, 0, "R6", "R3 R9", "R6");
      run_op(6'h02, 32'h10, 10'h020, 32'hFFFF_0000, 32'h0F0F_0F0F, 0, 0, "R7", "R4 R9", "R7");
      run_op(6'h12, 32'h10, 10'h3FC, 32'hA5A5_A5A5, 32'hFF00_00FF, 0, 0, "R12", "R4 R9", "R8");
      run_op(6'h13, 32'h1000, 10'h200, 32'h7777_0001, '0, 1, 0, "R12", "R2 R9", "R8");
      run_op(6'h03, 32'h24, 10'd4, 32'h5555_5555, 32'h0, 0, 1, "R7", "R3 R10", "R7");
      run_op(6'h22, 32'h30, 10'd0, 32'h1234_5678, 32'h0, 0, 0, "R6", "R4", "R6");
      run_op(6'h22, 32'h30, 10'd0, 32'h1234_5678, 32'hFFFF_FFFF, 0, 1, "R6", "R4 R10", "R6");
      run_op(6'h03, 32'h3C, 10'h3FC, 32'h0BAD_CAFE, '0, 1, 0, "R7", "R2 R9", "R7");

      run_bad(6'h33);
      run_bad(6'h01);
      run_bad(6'h32);
      run_bad(6'h00);
      run_bad(6'h21);

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule